// File: doc/BRIEF.md
# Ethernet MAC Control and Status Word

This block is a single 16-bit host-visible register that sits beside an Ethernet MAC. A read returns a snapshot of live line and transmit status together with a latched transmit-fault flag and the current on/off state of three MAC functions: the transmitter, the receiver and the statistics counters. Each function is switched by a pair of write-one strobes, one that turns it on and one that turns it off. Its present state is read back on a separate bit, so a host can change one function without a read-modify-write of the others.

The host reaches the word through a simple select/write/address/data bus at a fixed offset. Reads are combinational. A write takes effect on the clock edge that samples it. A transmit underrun reported by the datapath latches a fault flag and shuts the transmitter off in the same cycle. Only a transmit-reset strobe from the reset controller removes the fault. The enable states are also driven out as plain level outputs for the datapath. The status inputs are assumed to be synchronous to the block clock already.

Top module: `mac_ctl_reg`

## Requirements
- R1: After reset every stored state bit is 0, and a read at the register offset with all status inputs low returns 0x0000.
- R2: Read bit 0 follows the collision input, bit 1 follows the carrier-sense input and bit 2 follows the transmit-busy input, all in the same cycle and without latching.
- R3: A cycle with the underrun input high sets read bit 3 on the next clock edge. The bit stays set until a cycle with the transmit-reset strobe high clears it. If both are high in one cycle, the reset wins and bit 3 reads 0.
- R4: Writing 1 to bit 5 turns statistics on, and writing 1 to bit 6 turns them off. Bit 7 and output stats_en_o show the resulting state from the edge that takes the write.
- R5: Writing 1 to bit 8 turns the transmitter on, and writing 1 to bit 9 turns it off. Bit 10 and output tx_en_o show the state.
- R6: Writing 1 to bit 12 turns the receiver on, and writing 1 to bit 11 turns it off. Bit 13 and output rx_en_o show the state.
- R7: When the on and off strobes of one pair are both 1 in the same write, the function ends up off.
- R8: The strobe bits 5, 6, 8, 9, 11 and 12 and the reserved bits 4, 14 and 15 always read 0. Writing 0 to a strobe leaves its state unchanged. Writing to read-only bits 0–3, 7, 10 and 13 has no effect.
- R9: A transmit-reset strobe turns the transmitter off. An underrun turns it off on the same edge that sets bit 3, and this overrides an enable write in that cycle.
- R10: Only accesses at offset 0x52 reach the register. Writes at any other offset change nothing, and reads at any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Host access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Host offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, 0 when not selected at the offset |
| col_i | input | 1 | Live collision indication |
| crs_i | input | 1 | Live carrier-sense indication |
| tx_busy_i | input | 1 | Frame transmission in progress |
| tx_underrun_i | input | 1 | Transmit underrun event |
| tx_reset_i | input | 1 | Transmitter reset strobe |
| stats_en_o | output | 1 | Statistics enabled state |
| tx_en_o | output | 1 | Transmitter enabled state |
| rx_en_o | output | 1 | Receiver enabled state |

## Verification
The bench aims at the orderings that a plain flop-per-bit design gets wrong. If set and clear are both written in one access, a set-priority design would leave the function on. An underrun that arrives in the same cycle as a transmitter enable write would let the enable win if the forced clear had low priority. An underrun that coincides with a transmit-reset would leave a stuck fault if set beat clear. The bench also writes all-ones and all-zeros patterns to show that strobes read back 0, that writing 0 does not disturb a state, and that a write to the fault bit neither sets nor clears it. Accesses at a neighbouring offset catch a decoder that ignores the address.

// File: rtl/mac_ctl_pkg.sv
package mac_ctl_pkg;

  localparam int unsigned REG_W   = 16;
  localparam int unsigned NUM_EN  = 3;

  // enable pair indices
  localparam int unsigned EN_STATS = 0;
  localparam int unsigned EN_TX    = 1;
  localparam int unsigned EN_RX    = 2;

  // live status positions
  localparam int unsigned POS_COL   = 0;
  localparam int unsigned POS_CRS   = 1;
  localparam int unsigned POS_BUSY  = 2;
  localparam int unsigned POS_TXERR = 3;

  // strobe and state positions per enable pair
  localparam int unsigned EN_ON_POS  [NUM_EN] = '{5, 8, 12};
  localparam int unsigned EN_OFF_POS [NUM_EN] = '{6, 9, 11};
  localparam int unsigned EN_ST_POS  [NUM_EN] = '{7, 10, 13};

endpackage

// File: rtl/mac_ctl_rst_sync.sv
module mac_ctl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/mac_ctl_enable.sv
module mac_ctl_enable (
  input  logic clk,
  input  logic rst_n,
  input  logic on_stb,
  input  logic off_stb,
  input  logic force_off,
  output logic en_q
);

  logic en_d;
  logic en_ce;

  assign en_ce = on_stb | off_stb | force_off;

  always_comb begin
    if (force_off || off_stb) en_d = 1'b0;
    else                      en_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (en_ce) en_q <= en_d;
  end

  // R7
  off_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_stb && off_stb) |=> !en_q);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!on_stb && !off_stb && !force_off) |=> $stable(en_q));

endmodule

// File: rtl/mac_ctl_txerr.sv
module mac_ctl_txerr (
  input  logic clk,
  input  logic rst_n,
  input  logic underrun_i,
  input  logic txrst_i,
  output logic err_q
);

  logic err_d;
  logic err_ce;

  assign err_ce = underrun_i | txrst_i;

  always_comb begin
    if (txrst_i) err_d = 1'b0;
    else         err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_ce) err_q <= err_d;
  end

  // R3
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun_i && !txrst_i) |=> err_q);

  // R3
  err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txrst_i |=> !err_q);

  // R3
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!underrun_i && !txrst_i) |=> $stable(err_q));

endmodule

// File: rtl/mac_ctl_reg.sv
module mac_ctl_reg
  import mac_ctl_pkg::*;
#(
  parameter int unsigned        ADDR_W     = 8,
  parameter logic [ADDR_W-1:0]  REG_OFFSET = 8'h52
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              col_i,
  input  logic              crs_i,
  input  logic              tx_busy_i,
  input  logic              tx_underrun_i,
  input  logic              tx_reset_i,
  output logic              stats_en_o,
  output logic              tx_en_o,
  output logic              rx_en_o
);

  logic              rst_n_int;
  logic              hit;
  logic              wr_hit;
  logic              rd_hit;
  logic [NUM_EN-1:0] on_stb;
  logic [NUM_EN-1:0] off_stb;
  logic [NUM_EN-1:0] force_off;
  logic [NUM_EN-1:0] en_state;
  logic              tx_err;
  logic [REG_W-1:0]  rd_word;

  mac_ctl_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  assign hit    = bus_sel && (bus_addr == REG_OFFSET);
  assign wr_hit = hit && bus_wr;
  assign rd_hit = hit && !bus_wr;

  for (genvar g = 0; g < NUM_EN; g++) begin : g_en
    assign on_stb[g]  = wr_hit && bus_wdata[EN_ON_POS[g]];
    assign off_stb[g] = wr_hit && bus_wdata[EN_OFF_POS[g]];
    if (g == EN_TX) begin : g_force
      assign force_off[g] = tx_underrun_i | tx_reset_i;
    end else begin : g_noforce
      assign force_off[g] = 1'b0;
    end
    mac_ctl_enable u_en (
      .clk       (clk),
      .rst_n     (rst_n_int),
      .on_stb    (on_stb[g]),
      .off_stb   (off_stb[g]),
      .force_off (force_off[g]),
      .en_q      (en_state[g])
    );
  end

  mac_ctl_txerr u_txerr (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .underrun_i (tx_underrun_i),
    .txrst_i    (tx_reset_i),
    .err_q      (tx_err)
  );

  always_comb begin
    rd_word            = '0;
    rd_word[POS_COL]   = col_i;
    rd_word[POS_CRS]   = crs_i;
    rd_word[POS_BUSY]  = tx_busy_i;
    rd_word[POS_TXERR] = tx_err;
    for (int i = 0; i < NUM_EN; i++) begin
      rd_word[EN_ST_POS[i]] = en_state[i];
    end
  end

  assign bus_rdata  = rd_hit ? rd_word : '0;
  assign stats_en_o = en_state[EN_STATS];
  assign tx_en_o    = en_state[EN_TX];
  assign rx_en_o    = en_state[EN_RX];

  // R9
  underrun_txoff_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    tx_underrun_i |=> !tx_en_o);

  // R9
  txrst_txoff_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    tx_reset_i |=> !tx_en_o);

  // R10
  miss_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !rd_hit |-> (bus_rdata == '0));

  // R10
  miss_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!wr_hit && !tx_underrun_i && !tx_reset_i) |=> $stable({stats_en_o, tx_en_o, rx_en_o}));

endmodule

// File: tb/mac_ctl_reg_tb.sv
module mac_ctl_reg_tb;

  localparam logic [7:0] OFF = 8'h52;

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        col_i, crs_i, tx_busy_i, tx_underrun_i, tx_reset_i;
  logic        stats_en_o, tx_en_o, rx_en_o;

  int n_chk;
  int n_fail;
  bit done;

  mac_ctl_reg u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .col_i(col_i), .crs_i(crs_i), .tx_busy_i(tx_busy_i),
    .tx_underrun_i(tx_underrun_i), .tx_reset_i(tx_reset_i),
    .stats_en_o(stats_en_o), .tx_en_o(tx_en_o), .rx_en_o(rx_en_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic pulse_in(input bit ur, input bit rs);
    @(negedge clk);
    tx_underrun_i = ur; tx_reset_i = rs;
    @(negedge clk);
    tx_underrun_i = 1'b0; tx_reset_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] r;
    bus_read(OFF, r);
    check("R1 reset word", r, 16'h0000);
    check("R1 reset outputs", {13'd0, stats_en_o, tx_en_o, rx_en_o}, 16'h0000);
  endtask

  task automatic t_live();
    logic [15:0] r;
    @(negedge clk); col_i = 1'b1;
    bus_read(OFF, r); check("R2 collision bit0", r, 16'h0001);
    @(negedge clk); col_i = 1'b0; crs_i = 1'b1; tx_busy_i = 1'b1;
    bus_read(OFF, r); check("R2 carrier/busy bits1,2", r, 16'h0006);
    @(negedge clk); crs_i = 1'b0; tx_busy_i = 1'b0;
    bus_read(OFF, r); check("R2 live release", r, 16'h0000);
  endtask

  task automatic t_stats();
    logic [15:0] r;
    bus_write(OFF, 16'h0020);
    bus_read(OFF, r); check("R4 stats on bit7", r, 16'h0080);
    check("R4 stats_en_o", {15'd0, stats_en_o}, 16'h0001);
    bus_write(OFF, 16'h0040);
    bus_read(OFF, r); check("R4 stats off", r, 16'h0000);
  endtask

  task automatic t_tx();
    logic [15:0] r;
    bus_write(OFF, 16'h0100);
    bus_read(OFF, r); check("R5 tx on bit10", r, 16'h0400);
    check("R5 tx_en_o", {15'd0, tx_en_o}, 16'h0001);
    bus_write(OFF, 16'h0200);
    bus_read(OFF, r); check("R5 tx off", r, 16'h0000);
  endtask

  task automatic t_rx();
    logic [15:0] r;
    bus_write(OFF, 16'h1000);
    bus_read(OFF, r); check("R6 rx on bit13", r, 16'h2000);
    check("R6 rx_en_o", {15'd0, rx_en_o}, 16'h0001);
    bus_write(OFF, 16'h0800);
    bus_read(OFF, r); check("R6 rx off", r, 16'h0000);
  endtask

  task automatic t_both();
    logic [15:0] r;
    bus_write(OFF, 16'h1120);
    bus_write(OFF, 16'h1B60);
    bus_read(OFF, r); check("R7 on+off gives off", r, 16'h0000);
  endtask

  task automatic t_strobes();
    logic [15:0] r;
    bus_write(OFF, 16'h1120);
    bus_write(OFF, 16'h0000);
    bus_read(OFF, r); check("R8 write zero keeps states", r, 16'h2480);
    bus_write(OFF, 16'h2488);
    bus_read(OFF, r); check("R8 RO write ignored, strobes read 0", r, 16'h2480);
    bus_write(OFF, 16'h1B60);
    bus_write(OFF, 16'hE49F);
    bus_read(OFF, r); check("R8 RO/reserved writes ignored", r, 16'h0000);
  endtask

  task automatic t_txerr();
    logic [15:0] r;
    bus_write(OFF, 16'h0100);
    pulse_in(1'b1, 1'b0);
    bus_read(OFF, r); check("R3/R9 underrun sets bit3, tx off", r, 16'h0008);
    repeat (3) @(negedge clk);
    bus_read(OFF, r); check("R3 sticky", r, 16'h0008);
    bus_write(OFF, 16'h0008);
    bus_read(OFF, r); check("R8 write to bit3 ignored", r, 16'h0008);
    pulse_in(1'b0, 1'b1);
    bus_read(OFF, r); check("R3 tx reset clears", r, 16'h0000);
    pulse_in(1'b1, 1'b1);
    bus_read(OFF, r); check("R3 reset wins same cycle", r, 16'h0000);
    bus_write(OFF, 16'h0100);
    pulse_in(1'b0, 1'b1);
    bus_read(OFF, r); check("R9 tx reset turns tx off", r, 16'h0000);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = OFF; bus_wdata = 16'h0100;
    tx_underrun_i = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0; tx_underrun_i = 1'b0;
    bus_read(OFF, r); check("R9 underrun beats enable write", r, 16'h0008);
    pulse_in(1'b0, 1'b1);
  endtask

  task automatic t_addr();
    logic [15:0] r;
    bus_write(OFF + 8'd1, 16'h1120);
    bus_read(OFF, r); check("R10 other offset write ignored", r, 16'h0000);
    bus_write(OFF, 16'h1120);
    @(negedge clk); col_i = 1'b1;
    bus_read(OFF - 8'd2, r); check("R10 other offset reads 0", r, 16'h0000);
    @(negedge clk); col_i = 1'b0;
    bus_write(OFF, 16'h0B40);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    col_i = 1'b0; crs_i = 1'b0; tx_busy_i = 1'b0; tx_underrun_i = 1'b0; tx_reset_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_live();
    t_stats();
    t_tx();
    t_rx();
    t_both();
    t_strobes();
    t_txerr();
    t_addr();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule